// File: doc/BRIEF.md
# FP8 Floating-Point Adder

This block adds two 8-bit floating-point numbers and returns their sum in the same format. Each word has a sign bit in bit 7, a 5-bit biased exponent in bits 6:2 (bias 15) and a 2-bit fraction in bits 1:0. The block has no clock and no state: the sum settles from the two operands through one combinational path. It is meant to be placed inside a multiply-accumulate datapath or a small vector unit, where the caller registers the inputs and outputs as it needs.

Inside, each operand is first sorted into one of five classes: CLS_ZERO, CLS_SUB, CLS_NORM, CLS_INF and CLS_NAN. The larger-magnitude operand is chosen. The smaller one is shifted right to line up with it, and the bits shifted out are kept as guard, round and sticky bits. The significands are then added or subtracted. The raw sum is normalised without letting the exponent drop below the subnormal floor, and rounded to nearest with ties to even. A result selector then picks one of five result paths. PATH_NAN is taken for any NaN input or for infinities of opposite sign. PATH_INF_A or PATH_INF_B passes an infinite operand through. PATH_ZERO is taken when the significands cancel exactly. PATH_FINITE covers every other case.

Top module: `fp8_adder`

## Requirements
- R1: If either operand has exponent field 11111 and a non-zero fraction (a NaN), the output is the quiet NaN 0x7E (sign 0, exponent 11111, fraction 10).
- R2: The sum of +infinity (0x7C) and -infinity (0xFC), in either order, is 0x7E.
- R3: If exactly one operand is infinite, or both are infinite with the same sign, and neither is a NaN, the output is that infinity with its sign.
- R4: For finite operands whose exact sum can be represented, the output is the encoding of that sum. A normal value with exponent field e and fraction m equals (1 + m/4) * 2^(e-15).
- R5: For finite operands whose exact sum cannot be represented, the output is the nearest finite value. When the sum lies exactly halfway between two values, the output is the one whose fraction LSB (bit 0) is 0.
- R6: An exponent field of 00000 encodes m * 2^-16 with no hidden one. Sums that fall in or cross the subnormal range are exact: 0x01+0x01 gives 0x02, 0x03+0x01 gives 0x04 and 0x04+0x81 gives 0x03.
- R7: A finite sum whose magnitude, after rounding, exceeds the largest finite value 0x7B (57344) gives infinity with the sign of the sum. This includes the halfway case at 61440.
- R8: When the exact sum of finite operands is zero, the output is +0 (0x00). The one exception is (-0)+(-0), which gives -0 (0x80).
- R9: The result does not depend on operand order: a+b and b+a give the same output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First addend, sign/exponent/fraction |
| opnd_b | input | 8 | Second addend, sign/exponent/fraction |
| sum_out | output | 8 | Rounded sum in the same format |

## Verification
The hardest cases to reach are the narrow rounding boundaries. One is an exact tie at the top of the range, where ties-to-even must carry into infinity. Another is the step from subnormal to normal, where the carry out of the fraction has to become exponent 00001. Directed pairs are built around these values: 0x7B+0x6C, the 1.0+0.125 and 1.25+0.125 ties, and 0x03+0x01. Every one of the 65536 operand pairs is then applied in turn and compared with a reference. The reference works on exact scaled integers and searches all finite codes for the nearest one, so every alignment distance and every cancellation depth is covered.

// File: rtl/fp8_pkg.sv
package fp8_pkg;

    // Operand classes seen by the result selector
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opnd_cls_e;

    // Result path chosen by the top-level selector
    typedef enum logic [2:0] {
        PATH_NAN,
        PATH_INF_A,
        PATH_INF_B,
        PATH_ZERO,
        PATH_FINITE
    } res_path_e;

    // Guard, round and sticky bits kept below the fraction
    localparam int unsigned GRS_W = 3;

endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
    import fp8_pkg::*;
#(
    parameter int unsigned EXP_W = 5,
    parameter int unsigned MAN_W = 2
) (
    input  logic [EXP_W+MAN_W:0] opnd,
    output logic                 sign,
    output opnd_cls_e            cls,
    output logic [EXP_W-1:0]     eff_exp,
    output logic [MAN_W:0]       sig
);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max;
    logic             exp_min;
    logic             man_nz;

    assign sign    = opnd[EXP_W+MAN_W];
    assign exp_f   = opnd[EXP_W+MAN_W-1:MAN_W];
    assign man_f   = opnd[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign man_nz  = |man_f;

    always_comb begin
        if (exp_max) begin
            cls = man_nz ? CLS_NAN : CLS_INF;
        end else if (exp_min) begin
            cls = man_nz ? CLS_SUB : CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
    end

    // Subnormals share the scale of the smallest normal, with no hidden one
    always_comb begin
        eff_exp = exp_min ? EXP_W'(1) : exp_f;
        sig     = {~exp_min, man_f};
    end

endmodule

// File: rtl/fp8_align_add.sv
module fp8_align_add
    import fp8_pkg::*;
#(
    parameter int unsigned EXP_W = 5,
    parameter int unsigned MAN_W = 2
) (
    input  logic                         a_sign,
    input  logic [EXP_W-1:0]             a_exp,
    input  logic [MAN_W:0]               a_sig,
    input  logic                         b_sign,
    input  logic [EXP_W-1:0]             b_exp,
    input  logic [MAN_W:0]               b_sig,
    output logic                         sum_sign,
    output logic [EXP_W-1:0]             sum_exp,
    output logic [MAN_W+GRS_W+1:0]       sum_raw
);

    localparam int unsigned SIG_W = MAN_W + 1;
    localparam int unsigned EXT_W = SIG_W + GRS_W;
    localparam int unsigned RAW_W = EXT_W + 1;

    logic             a_big;
    logic [EXP_W-1:0] big_exp;
    logic [EXP_W-1:0] small_exp;
    logic [EXP_W-1:0] shift_amt;
    logic [EXT_W-1:0] big_ext;
    logic [EXT_W-1:0] small_ext;
    logic [EXT_W-1:0] shifted;
    logic [EXT_W-1:0] aligned;
    logic             sticky;
    logic             eff_sub;

    // Magnitude order: exponent first, then significand
    assign a_big     = {a_exp, a_sig} >= {b_exp, b_sig};
    assign big_exp   = a_big ? a_exp : b_exp;
    assign small_exp = a_big ? b_exp : a_exp;
    assign big_ext   = a_big ? {a_sig, {GRS_W{1'b0}}} : {b_sig, {GRS_W{1'b0}}};
    assign small_ext = a_big ? {b_sig, {GRS_W{1'b0}}} : {a_sig, {GRS_W{1'b0}}};
    assign shift_amt = big_exp - small_exp;
    assign eff_sub   = a_sign ^ b_sign;

    always_comb begin
        shifted = '0;
        sticky  = 1'b0;
        if (int'(shift_amt) >= EXT_W) begin
            sticky = |small_ext;
        end else begin
            shifted = small_ext >> shift_amt;
            for (int i = 0; i < EXT_W; i++) begin
                if (i < int'(shift_amt)) begin
                    sticky = sticky | small_ext[i];
                end
            end
        end
        aligned = {shifted[EXT_W-1:1], shifted[0] | sticky};
    end

    always_comb begin
        if (eff_sub) begin
            sum_raw = RAW_W'(big_ext) - RAW_W'(aligned);
        end else begin
            sum_raw = RAW_W'(big_ext) + RAW_W'(aligned);
        end
        sum_sign = a_big ? a_sign : b_sign;
        sum_exp  = big_exp;
    end

    // The larger magnitude is the minuend, so subtraction never borrows
    always_comb begin
        AST_NO_BORROW: assert (!eff_sub || !sum_raw[RAW_W-1]); // R4
    end

endmodule

// File: rtl/fp8_norm_round.sv
module fp8_norm_round
    import fp8_pkg::*;
#(
    parameter int unsigned EXP_W = 5,
    parameter int unsigned MAN_W = 2
) (
    input  logic [MAN_W+GRS_W+1:0] sum_raw,
    input  logic [EXP_W-1:0]       sum_exp,
    output logic [EXP_W+MAN_W-1:0] mag_out,
    output logic                   is_zero
);

    localparam int unsigned SIG_W  = MAN_W + 1;
    localparam int unsigned EXT_W  = SIG_W + GRS_W;
    localparam int unsigned RAW_W  = EXT_W + 1;
    localparam int unsigned EXW    = EXP_W + 2;
    localparam int unsigned PACK_W = EXW + MAN_W;
    localparam int unsigned EXP_ONES = (1 << EXP_W) - 1;

    int               lead_zeros;
    int               floor_lim;
    int               lshift;
    logic             found;
    logic [EXT_W-1:0] norm;
    logic [EXW-1:0]   exp_n;
    logic             guard;
    logic             rest;
    logic             inc;
    logic [PACK_W-1:0] pre;
    logic [PACK_W-1:0] rounded;
    logic             ovf;

    assign is_zero = ~|sum_raw;

    // Leading-zero count below the carry position
    always_comb begin
        lead_zeros = EXT_W;
        found      = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!found && sum_raw[i]) begin
                lead_zeros = EXT_W - 1 - i;
                found      = 1'b1;
            end
        end
        floor_lim = int'(sum_exp) - 1;
        lshift    = (lead_zeros < floor_lim) ? lead_zeros : floor_lim;
    end

    always_comb begin
        if (sum_raw[RAW_W-1]) begin
            norm    = sum_raw[RAW_W-1:1];
            norm[0] = sum_raw[1] | sum_raw[0];
            exp_n   = EXW'(sum_exp) + EXW'(1);
        end else begin
            norm  = sum_raw[EXT_W-1:0] << lshift;
            exp_n = norm[EXT_W-1] ? (EXW'(sum_exp) - EXW'(lshift)) : '0;
        end
    end

    // Round to nearest, ties to even; the carry ripples into the exponent
    always_comb begin
        guard   = norm[GRS_W-1];
        rest    = |norm[GRS_W-2:0];
        inc     = guard & (rest | norm[GRS_W]);
        pre     = {exp_n, norm[GRS_W+MAN_W-1:GRS_W]};
        rounded = pre + PACK_W'(inc);
        ovf     = rounded[PACK_W-1:MAN_W] >= EXW'(EXP_ONES);
        mag_out = ovf ? {{EXP_W{1'b1}}, {MAN_W{1'b0}}} : rounded[EXP_W+MAN_W-1:0];
    end

    always_comb begin
        AST_NO_OVERFLOW: assert (is_zero || !(&mag_out[EXP_W+MAN_W-1:MAN_W]) || (mag_out[MAN_W-1:0] == '0)); // R7
        AST_SUBNORMAL_EXACT: assert (!(sum_exp == EXP_W'(1) && !sum_raw[RAW_W-1]) || !inc); // R6
    end

endmodule

// File: rtl/fp8_adder.sv
module fp8_adder
    import fp8_pkg::*;
#(
    parameter int unsigned EXP_W = 5,
    parameter int unsigned MAN_W = 2
) (
    input  logic [EXP_W+MAN_W:0] opnd_a,
    input  logic [EXP_W+MAN_W:0] opnd_b,
    output logic [EXP_W+MAN_W:0] sum_out
);

    localparam int unsigned WORD_W = EXP_W + MAN_W + 1;
    localparam int unsigned RAW_W  = MAN_W + 1 + GRS_W + 1;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic             a_sign, b_sign;
    opnd_cls_e        a_cls, b_cls;
    logic [EXP_W-1:0] a_exp, b_exp;
    logic [MAN_W:0]   a_sig, b_sig;
    logic             s_sign;
    logic [EXP_W-1:0] s_exp;
    logic [RAW_W-1:0] s_raw;
    logic [EXP_W+MAN_W-1:0] s_mag;
    logic             s_zero;
    res_path_e        path;

    fp8_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unpack_a (
        .opnd(opnd_a), .sign(a_sign), .cls(a_cls), .eff_exp(a_exp), .sig(a_sig)
    );

    fp8_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_unpack_b (
        .opnd(opnd_b), .sign(b_sign), .cls(b_cls), .eff_exp(b_exp), .sig(b_sig)
    );

    fp8_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_align_add (
        .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
        .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
        .sum_sign(s_sign), .sum_exp(s_exp), .sum_raw(s_raw)
    );

    fp8_norm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_norm_round (
        .sum_raw(s_raw), .sum_exp(s_exp), .mag_out(s_mag), .is_zero(s_zero)
    );

    // Path selection: NaN outranks infinity, infinity outranks finite sums
    always_comb begin
        if (a_cls == CLS_NAN || b_cls == CLS_NAN) begin
            path = PATH_NAN;
        end else if (a_cls == CLS_INF && b_cls == CLS_INF && a_sign != b_sign) begin
            path = PATH_NAN;
        end else if (a_cls == CLS_INF) begin
            path = PATH_INF_A;
        end else if (b_cls == CLS_INF) begin
            path = PATH_INF_B;
        end else if (s_zero) begin
            path = PATH_ZERO;
        end else begin
            path = PATH_FINITE;
        end
    end

    always_comb begin
        unique case (path)
            PATH_NAN:    sum_out = QNAN;
            PATH_INF_A:  sum_out = opnd_a;
            PATH_INF_B:  sum_out = opnd_b;
            PATH_ZERO:   sum_out = {a_sign & b_sign, {(WORD_W-1){1'b0}}};
            PATH_FINITE: sum_out = {s_sign, s_mag};
            default:     sum_out = QNAN;
        endcase
    end

    // Port-level checks, decoded straight from the operand words
    logic a_is_nan, b_is_nan, a_is_inf, b_is_inf;
    assign a_is_nan = (&opnd_a[WORD_W-2:MAN_W]) && (|opnd_a[MAN_W-1:0]);
    assign b_is_nan = (&opnd_b[WORD_W-2:MAN_W]) && (|opnd_b[MAN_W-1:0]);
    assign a_is_inf = (&opnd_a[WORD_W-2:MAN_W]) && !(|opnd_a[MAN_W-1:0]);
    assign b_is_inf = (&opnd_b[WORD_W-2:MAN_W]) && !(|opnd_b[MAN_W-1:0]);

    always_comb begin
        AST_NAN_OUT: assert (!(a_is_nan || b_is_nan) || sum_out == QNAN); // R1
        AST_INF_CLASH: assert (!(a_is_inf && b_is_inf && opnd_a[WORD_W-1] != opnd_b[WORD_W-1]) || sum_out == QNAN); // R2
        AST_INF_PASS: assert (!(a_is_inf && !b_is_nan && !b_is_inf) || sum_out == opnd_a); // R3
        AST_NEG_ZERO: assert (!(opnd_a == {1'b1, {(WORD_W-1){1'b0}}} && opnd_b == opnd_a) || sum_out == opnd_a); // R8
    end

endmodule

// File: tb/test_fp8_adder.sv
module test_fp8_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] sum_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fp8_adder i_fp8_adder (
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .sum_out(sum_out)
    );

    // Magnitude scaled by 2^16 so every finite value is an integer
    function automatic longint mag_of(input logic [7:0] c);
        longint m = longint'(c[1:0]);
        int     e = int'(c[6:2]);
        if (e == 0) return m;
        return (64'd4 + m) << (e - 1);
    endfunction

    function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b,
                                           output string tag);
        bit     an = (a[6:2] == 5'h1F) && (a[1:0] != 2'b00);
        bit     bn = (b[6:2] == 5'h1F) && (b[1:0] != 2'b00);
        bit     ai = (a[6:2] == 5'h1F) && (a[1:0] == 2'b00);
        bit     bi = (b[6:2] == 5'h1F) && (b[1:0] == 2'b00);
        longint va, vb, s, mag, best_d, d;
        logic [7:0] best;
        bit     neg;
        if (an || bn) begin tag = "R1"; return 8'h7E; end
        if (ai && bi && a[7] != b[7]) begin tag = "R2"; return 8'h7E; end
        if (ai) begin tag = "R3"; return a; end
        if (bi) begin tag = "R3"; return b; end
        va = a[7] ? -mag_of(a) : mag_of(a);
        vb = b[7] ? -mag_of(b) : mag_of(b);
        s  = va + vb;
        if (s == 0) begin
            tag = "R8";
            return (a[7] & b[7]) ? 8'h80 : 8'h00;
        end
        neg = (s < 0);
        mag = neg ? -s : s;
        if (2 * mag >= 64'd15 * (64'd1 << 29)) begin
            tag = "R7";
            return {neg, 7'h7C};
        end
        best   = 8'h00;
        best_d = -1;
        for (int c = 0; c <= 8'h7B; c++) begin
            d = mag - mag_of(8'(c));
            if (d < 0) d = -d;
            if (best_d < 0 || d < best_d || (d == best_d && c[0] == 1'b0)) begin
                best_d = d;
                best   = 8'(c);
            end
        end
        if (a[6:2] == 5'h00 || b[6:2] == 5'h00) tag = "R6";
        else if (best_d == 0) tag = "R4";
        else tag = "R5";
        return {neg, best[6:0]};
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        #1;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] expv);
        n_checks++;
        if (sum_out !== expv) begin
            n_fail++;
            $display("FAIL %s: %02h + %02h gave %02h, expected %02h", tag, a, b, sum_out, expv);
        end
    endtask

    task automatic directed(input string tag, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] expv);
        drive(a, b);
        check(tag, a, b, expv);
    endtask

    initial begin
        logic [7:0] first;
        string      t;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: NaN in either slot
        directed("R1", 8'h7D, 8'h3C, 8'h7E);
        directed("R1", 8'h3C, 8'hFF, 8'h7E);
        // R2: opposite infinities
        directed("R2", 8'h7C, 8'hFC, 8'h7E);
        directed("R2", 8'hFC, 8'h7C, 8'h7E);
        // R3: infinity passes through
        directed("R3", 8'hFC, 8'h3C, 8'hFC);
        directed("R3", 8'h7C, 8'h7C, 8'h7C);
        // R4: exact sums
        directed("R4", 8'h3C, 8'h3C, 8'h40);
        directed("R4", 8'h40, 8'hBC, 8'h3C);
        // R5: ties go to even fraction
        directed("R5", 8'h3C, 8'h30, 8'h3C);
        directed("R5", 8'h3D, 8'h30, 8'h3E);
        // R6: subnormal range and crossing
        directed("R6", 8'h01, 8'h01, 8'h02);
        directed("R6", 8'h03, 8'h01, 8'h04);
        directed("R6", 8'h04, 8'h81, 8'h03);
        // R7: overflow, including the halfway tie at the top
        directed("R7", 8'h7B, 8'h7B, 8'h7C);
        directed("R7", 8'hFB, 8'hFB, 8'hFC);
        directed("R7", 8'h7B, 8'h6C, 8'h7C);
        // R8: cancellation and signed zeros
        directed("R8", 8'h3C, 8'hBC, 8'h00);
        directed("R8", 8'h80, 8'h80, 8'h80);
        directed("R8", 8'h00, 8'h80, 8'h00);
        // R9: operand order
        drive(8'h3D, 8'h31);
        first = sum_out;
        drive(8'h31, 8'h3D);
        check("R9", 8'h31, 8'h3D, first);
        drive(8'h85, 8'h0B);
        first = sum_out;
        drive(8'h0B, 8'h85);
        check("R9", 8'h0B, 8'h85, first);

        // Every operand pair against the behavioural reference
        for (int i = 0; i < 65536; i++) begin
            logic [7:0] xa = 8'(i >> 8);
            logic [7:0] xb = 8'(i);
            logic [7:0] want = ref_add(xa, xb, t);
            drive(xa, xb);
            check(t, xa, xb, want);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule